// File: doc/BRIEF.md
# Segmented Memory Protection Unit

The block decides whether a load, store or instruction fetch may proceed by looking its address up in a table of programmable foreground segments. Each segment is defined only by its start address. A segment covers everything from its own start up to the start of the next segment in table order, and the last segment runs to the top of the address space. When exactly one foreground segment matches and that segment is enabled, its attribute governs the access. In every other non-overlapping case a fixed background map, set by parameters, supplies the attribute. Overlapping foreground segments produce a multi-hit fault.

A 4-bit rights code in the attribute is decoded separately for ring 0 and for the outer rings, and the decoded rights are compared with the access kind. The verdict and an exception cause are registered and appear one cycle after the request. Register-style side ports do the rest. One port writes a segment, which updates its start address, attribute and enable bit together. One writes the whole enable mask. One reads a segment back combinationally. One probes an address and returns its attribute together with segment information.

Top module: `mpu_seg_guard`

## Requirements
- R1: Foreground segment i matches an address when the address is at or above its start and either i is the last segment or the address is below the start of segment i+1.
- R2: Two or more foreground matches fault the access: res_ok_o=0, with cause 25 for a load or store and 17 for a fetch. A probe of such an address gives probe_fault_o=1 and probe_o=0.
- R3: A single match on an enabled segment uses that segment's attribute. No match, or a match on a disabled segment, uses the background map. The default background map is four quarters starting at 0x0, 0x4000_0000, 0x8000_0000 and 0xC000_0000, with attributes (bits 20:8) 0x007, 0x06F, 0x006 and 0x000.
- R4: For ring 0, rights codes (attribute bits 11:8) 7, 11 and 15 give read/write/execute; 6, 9, 10 and 14 give read/write; 5 and 13 give read/execute; every other code gives nothing.
- R5: For rings 1 to 3, codes 9 and 15 give read/write/execute; 11 and 13 give read/execute; 14 gives read/write; every other code gives nothing.
- R6: Access kind 0 is a load and needs read, 1 is a store and needs write, and 2 or 3 is a fetch and needs execute. A granted access gives res_ok_o=1 and cause 0. A denied access gives cause 28 for a load, 29 for a store and 20 for a fetch.
- R7: res_valid_o, res_ok_o and res_cause_o appear on the clock edge after the cycle in which chk_valid_i was high. res_valid_o is high only in that cycle.
- R8: A segment write selects the segment by seg_word_i[4:0]. It stores seg_word_i[20:8] as the attribute, the start address rounded down to 2^ALIGN_LOG2, and seg_addr_i[0] as the segment's enable bit. Readback gives rd_addr_o = start | enable in bit 0, and rd_attr_o = the attribute in bits 20:8 with all other bits zero.
- R9: A segment write whose segment number is not below FG_SEGS changes nothing. Readback of such an index returns zero on both outputs.
- R10: An enable-mask write keeps only the low FG_SEGS bits of en_data_i. en_o shows the mask zero-extended.
- R11: When an enable-mask write and a segment write fall in the same cycle, the segment write's enable bit wins for its own segment.
- R12: The probe result has three forms. For an enabled single match it is bit 31 set, the attribute in bits 20:8 and the segment number in bits 4:0. For a disabled single match it is the background attribute with the segment number in bits 4:0. With no match it is the background attribute with bit 30 set.
- R13: After reset the enable mask is zero, every start and attribute reads back zero, res_valid_o is low, and cfg_o reads FG_SEGS.
- R14: A check issued in the same cycle as a segment write is judged against the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_valid_i | input | 1 | Access check request |
| chk_addr_i | input | ADDR_W | Address of the access |
| chk_kind_i | input | 2 | 0 load, 1 store, 2/3 fetch |
| chk_ring_i | input | 2 | Privilege ring, 0 most privileged |
| res_valid_o | output | 1 | Verdict valid |
| res_ok_o | output | 1 | Access allowed |
| res_cause_o | output | 6 | Exception cause, 0 when allowed |
| seg_we_i | input | 1 | Segment write strobe |
| seg_word_i | input | 32 | Segment number [4:0] and attribute [20:8] |
| seg_addr_i | input | ADDR_W | Start address, bit 0 is the enable bit |
| en_we_i | input | 1 | Enable-mask write strobe |
| en_data_i | input | 32 | New enable mask |
| rd_sel_i | input | 5 | Segment to read back |
| rd_addr_o | output | ADDR_W | Start address with enable in bit 0 |
| rd_attr_o | output | 32 | Attribute in bits 20:8 |
| en_o | output | 32 | Current enable mask |
| cfg_o | output | 32 | Foreground segment count |
| probe_addr_i | input | ADDR_W | Address to probe |
| probe_o | output | 32 | Probe result |
| probe_fault_o | output | 1 | Probe hit more than one segment |

## Verification
Two pairs of functions can coincide. The first pair is an access check and a segment write. The bench raises chk_valid_i on the same edge that rewrites the rights of the segment under the checked address. It expects the verdict from the old rights, then repeats the check and expects the new verdict. The second pair is an enable-mask write and a segment write in one cycle. The mask written clears every bit, the segment write sets its own enable bit, and en_o must show that single bit.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int WORD_W   = 32;
  localparam int ATTR_LSB = 8;
  localparam int ATTR_W   = 13;
  localparam int SEL_W    = 5;
  localparam int CAUSE_W  = 6;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE        = 6'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_MULTI = 6'd17;
  localparam logic [CAUSE_W-1:0] CAUSE_LS_MULTI    = 6'd25;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_DENY  = 6'd20;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_DENY   = 6'd28;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_DENY  = 6'd29;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_FETCH_ALT = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;
endpackage

// File: rtl/mpu_matcher.sv
module mpu_matcher #(
  parameter int N  = 8,
  parameter int AW = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic [N*AW-1:0] start_i,
  input  logic [AW-1:0]   addr_i,
  output logic [N-1:0]    hit_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_hit
    if (i == N - 1) begin : g_last
      assign hit_o[i] = addr_i >= start_i[i*AW +: AW];
    end else begin : g_mid
      assign hit_o[i] = (addr_i >= start_i[i*AW +: AW]) &&
                        (addr_i <  start_i[(i+1)*AW +: AW]);
    end
  end

  // lowest matching index reported
  always_comb begin
    cnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_o[i]) begin
        cnt_o = cnt_o + CNT_W'(1);
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mpu_rights.sv
module mpu_rights
  import mpu_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       user_i,
  output perm_t      perm_o
);
  always_comb begin
    perm_o = '0;
    if (!user_i) begin
      case (code_i)
        4'd7, 4'd11, 4'd15:       perm_o = '{r: 1'b1, w: 1'b1, x: 1'b1};
        4'd6, 4'd9, 4'd10, 4'd14: perm_o = '{r: 1'b1, w: 1'b1, x: 1'b0};
        4'd5, 4'd13:              perm_o = '{r: 1'b1, w: 1'b0, x: 1'b1};
        default:                  perm_o = '0;
      endcase
    end else begin
      case (code_i)
        4'd9, 4'd15:  perm_o = '{r: 1'b1, w: 1'b1, x: 1'b1};
        4'd11, 4'd13: perm_o = '{r: 1'b1, w: 1'b0, x: 1'b1};
        4'd14:        perm_o = '{r: 1'b1, w: 1'b1, x: 1'b0};
        default:      perm_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mpu_seg_table.sv
module mpu_seg_table
  import mpu_pkg::*;
#(
  parameter int FG         = 8,
  parameter int AW         = 32,
  parameter int ALIGN_LOG2 = 12,
  localparam int IDX_W = (FG > 1) ? $clog2(FG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seg_we_i,
  input  logic [WORD_W-1:0]  seg_word_i,
  input  logic [AW-1:0]      seg_addr_i,
  input  logic               en_we_i,
  input  logic [WORD_W-1:0]  en_data_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [FG*AW-1:0]   start_o,
  output logic [FG*ATTR_W-1:0] attr_o,
  output logic [FG-1:0]      en_o,
  output logic [AW-1:0]      rd_addr_o,
  output logic [WORD_W-1:0]  rd_attr_o
);
  localparam logic [AW-1:0] ONE        = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] ALIGN_MASK = ~((ONE << ALIGN_LOG2) - ONE);

  logic [SEL_W-1:0] wr_sel;
  logic             wr_ok;
  logic [IDX_W-1:0] wr_idx;
  logic [FG-1:0]    en_q, en_d;

  assign wr_sel = seg_word_i[SEL_W-1:0];
  assign wr_ok  = seg_we_i && (32'(wr_sel) < FG);
  assign wr_idx = wr_sel[IDX_W-1:0];

  for (genvar i = 0; i < FG; i++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_o[i*AW +: AW]         <= '0;
        attr_o[i*ATTR_W +: ATTR_W]  <= '0;
      end else if (wr_ok && (wr_idx == IDX_W'(i))) begin
        start_o[i*AW +: AW]         <= seg_addr_i & ALIGN_MASK;
        attr_o[i*ATTR_W +: ATTR_W]  <= seg_word_i[ATTR_LSB +: ATTR_W];
      end
    end

    AST_START_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_o[i*AW +: AW] & ~ALIGN_MASK) == '0); // R8
  end

  // segment write's enable bit overrides a same-cycle mask write
  always_comb begin
    en_d = en_we_i ? en_data_i[FG-1:0] : en_q;
    if (wr_ok) en_d[wr_idx] = seg_addr_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  always_comb begin
    rd_addr_o = '0;
    rd_attr_o = '0;
    for (int i = 0; i < FG; i++) begin
      if (rd_sel_i == SEL_W'(i)) begin
        rd_addr_o = start_o[i*AW +: AW] | AW'(en_q[i]);
        rd_attr_o = WORD_W'(attr_o[i*ATTR_W +: ATTR_W]) << ATTR_LSB;
      end
    end
  end

  AST_IGNORED_SEG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_we_i && !wr_ok && !en_we_i) |=> ($stable(start_o) && $stable(attr_o) && $stable(en_q))); // R9
  AST_SEG_EN_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (en_q[$past(wr_idx)] == $past(seg_addr_i[0]))); // R11
  AST_EN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && !seg_we_i) |=> (en_q == $past(en_data_i[FG-1:0]))); // R10
endmodule

// File: rtl/mpu_seg_guard.sv
module mpu_seg_guard
  import mpu_pkg::*;
#(
  parameter int FG_SEGS    = 8,
  parameter int BG_SEGS    = 4,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_LOG2 = 12,
  parameter logic [BG_SEGS*ADDR_W-1:0] BG_START =
    {32'hC000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000},
  parameter logic [BG_SEGS*13-1:0] BG_ATTR =
    {13'h0000, 13'h0006, 13'h006F, 13'h0007}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                chk_valid_i,
  input  logic [ADDR_W-1:0]   chk_addr_i,
  input  logic [1:0]          chk_kind_i,
  input  logic [1:0]          chk_ring_i,
  output logic                res_valid_o,
  output logic                res_ok_o,
  output logic [5:0]          res_cause_o,
  input  logic                seg_we_i,
  input  logic [31:0]         seg_word_i,
  input  logic [ADDR_W-1:0]   seg_addr_i,
  input  logic                en_we_i,
  input  logic [31:0]         en_data_i,
  input  logic [4:0]          rd_sel_i,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic [31:0]         rd_attr_o,
  output logic [31:0]         en_o,
  output logic [31:0]         cfg_o,
  input  logic [ADDR_W-1:0]   probe_addr_i,
  output logic [31:0]         probe_o,
  output logic                probe_fault_o
);
  localparam int FG_IDX_W = (FG_SEGS > 1) ? $clog2(FG_SEGS) : 1;
  localparam int BG_IDX_W = (BG_SEGS > 1) ? $clog2(BG_SEGS) : 1;
  localparam int FG_CNT_W = $clog2(FG_SEGS + 1);
  localparam int BG_CNT_W = $clog2(BG_SEGS + 1);

  logic [FG_SEGS*ADDR_W-1:0] fg_start;
  logic [FG_SEGS*ATTR_W-1:0] fg_attr;
  logic [FG_SEGS-1:0]        fg_en;

  mpu_seg_table #(.FG(FG_SEGS), .AW(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_table (
    .clk_i, .rst_ni, .seg_we_i, .seg_word_i, .seg_addr_i, .en_we_i, .en_data_i,
    .rd_sel_i, .start_o(fg_start), .attr_o(fg_attr), .en_o(fg_en),
    .rd_addr_o, .rd_attr_o
  );

  assign en_o  = WORD_W'(fg_en);
  assign cfg_o = WORD_W'(FG_SEGS);

  // ---------------- access check path ----------------
  logic [FG_SEGS-1:0]  c_fg_hit;
  logic [FG_CNT_W-1:0] c_fg_cnt;
  logic [FG_IDX_W-1:0] c_fg_idx;
  logic [BG_SEGS-1:0]  c_bg_hit;
  logic [BG_CNT_W-1:0] c_bg_cnt;
  logic [BG_IDX_W-1:0] c_bg_idx;

  mpu_matcher #(.N(FG_SEGS), .AW(ADDR_W)) u_fg_chk (
    .start_i(fg_start), .addr_i(chk_addr_i),
    .hit_o(c_fg_hit), .cnt_o(c_fg_cnt), .idx_o(c_fg_idx)
  );
  mpu_matcher #(.N(BG_SEGS), .AW(ADDR_W)) u_bg_chk (
    .start_i(BG_START), .addr_i(chk_addr_i),
    .hit_o(c_bg_hit), .cnt_o(c_bg_cnt), .idx_o(c_bg_idx)
  );

  logic              c_multi, c_fg_use;
  logic [ATTR_W-1:0] c_attr;
  perm_t             c_perm;
  logic              c_grant;
  logic [CAUSE_W-1:0] c_cause;
  acc_kind_e         c_kind;

  assign c_kind   = acc_kind_e'(chk_kind_i);
  assign c_multi  = c_fg_cnt > FG_CNT_W'(1);
  assign c_fg_use = (c_fg_cnt == FG_CNT_W'(1)) && fg_en[c_fg_idx];
  assign c_attr   = c_fg_use ? fg_attr[c_fg_idx*ATTR_W +: ATTR_W]
                             : BG_ATTR[c_bg_idx*ATTR_W +: ATTR_W];

  mpu_rights u_rights (
    .code_i(c_attr[3:0]), .user_i(chk_ring_i != 2'd0), .perm_o(c_perm)
  );

  always_comb begin
    case (c_kind)
      ACC_LOAD:  c_grant = c_perm.r;
      ACC_STORE: c_grant = c_perm.w;
      default:   c_grant = c_perm.x;
    endcase
    if (c_multi) begin
      c_cause = (c_kind == ACC_LOAD || c_kind == ACC_STORE) ? CAUSE_LS_MULTI
                                                           : CAUSE_FETCH_MULTI;
    end else if (!c_grant) begin
      case (c_kind)
        ACC_LOAD:  c_cause = CAUSE_LOAD_DENY;
        ACC_STORE: c_cause = CAUSE_STORE_DENY;
        default:   c_cause = CAUSE_FETCH_DENY;
      endcase
    end else begin
      c_cause = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_ok_o    <= 1'b0;
      res_cause_o <= CAUSE_NONE;
    end else begin
      res_valid_o <= chk_valid_i;
      if (chk_valid_i) begin
        res_ok_o    <= (c_cause == CAUSE_NONE);
        res_cause_o <= c_cause;
      end
    end
  end

  // ---------------- probe path ----------------
  logic [FG_SEGS-1:0]  p_fg_hit;
  logic [FG_CNT_W-1:0] p_fg_cnt;
  logic [FG_IDX_W-1:0] p_fg_idx;
  logic [BG_SEGS-1:0]  p_bg_hit;
  logic [BG_CNT_W-1:0] p_bg_cnt;
  logic [BG_IDX_W-1:0] p_bg_idx;

  mpu_matcher #(.N(FG_SEGS), .AW(ADDR_W)) u_fg_prb (
    .start_i(fg_start), .addr_i(probe_addr_i),
    .hit_o(p_fg_hit), .cnt_o(p_fg_cnt), .idx_o(p_fg_idx)
  );
  mpu_matcher #(.N(BG_SEGS), .AW(ADDR_W)) u_bg_prb (
    .start_i(BG_START), .addr_i(probe_addr_i),
    .hit_o(p_bg_hit), .cnt_o(p_bg_cnt), .idx_o(p_bg_idx)
  );

  logic              p_single, p_none;
  logic [SEL_W-1:0]  p_seg;
  logic [ATTR_W-1:0] p_fg_attr, p_bg_attr;

  assign p_single  = p_fg_cnt == FG_CNT_W'(1);
  assign p_none    = p_fg_cnt == '0;
  assign p_seg     = SEL_W'(p_fg_idx);
  assign p_fg_attr = fg_attr[p_fg_idx*ATTR_W +: ATTR_W];
  assign p_bg_attr = BG_ATTR[p_bg_idx*ATTR_W +: ATTR_W];

  always_comb begin
    probe_fault_o = p_fg_cnt > FG_CNT_W'(1);
    if (probe_fault_o) begin
      probe_o = '0;
    end else if (p_single && fg_en[p_fg_idx]) begin
      probe_o = {1'b1, 10'b0, p_fg_attr, 3'b0, p_seg};
    end else begin
      probe_o = {1'b0, p_none, 9'b0, p_bg_attr, 3'b0, p_none ? 5'd0 : p_seg};
    end
  end

  AST_RES_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> res_valid_o); // R7
  AST_RES_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |=> !res_valid_o); // R7
  AST_OK_NO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ok_o) |-> (res_cause_o == CAUSE_NONE)); // R6
  AST_DENY_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ok_o) |-> (res_cause_o != CAUSE_NONE)); // R6
  AST_MULTI_PROBE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_fault_o |-> (probe_o == '0)); // R2
  AST_PROBE_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(probe_o[31] && probe_o[30])); // R12
  AST_BG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_bg_cnt == BG_CNT_W'(1)); // R3
endmodule

// File: tb/mpu_seg_guard_bench.sv
module mpu_seg_guard_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 17;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        chk_valid_i = 1'b0;
  logic [31:0] chk_addr_i = '0;
  logic [1:0]  chk_kind_i = '0;
  logic [1:0]  chk_ring_i = '0;
  logic        res_valid_o, res_ok_o;
  logic [5:0]  res_cause_o;
  logic        seg_we_i = 1'b0;
  logic [31:0] seg_word_i = '0;
  logic [31:0] seg_addr_i = '0;
  logic        en_we_i = 1'b0;
  logic [31:0] en_data_i = '0;
  logic [4:0]  rd_sel_i = '0;
  logic [31:0] rd_addr_o, rd_attr_o, en_o, cfg_o;
  logic [31:0] probe_addr_i = '0;
  logic [31:0] probe_o;
  logic        probe_fault_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mpu_seg_guard u_mpu_seg_guard (
    .clk_i, .rst_ni, .chk_valid_i, .chk_addr_i, .chk_kind_i, .chk_ring_i,
    .res_valid_o, .res_ok_o, .res_cause_o, .seg_we_i, .seg_word_i, .seg_addr_i,
    .en_we_i, .en_data_i, .rd_sel_i, .rd_addr_o, .rd_attr_o, .en_o, .cfg_o,
    .probe_addr_i, .probe_o, .probe_fault_o
  );

  // {addr, kind, ring, exp_ok, exp_cause}
  localparam logic [42:0] VEC [NV] = '{
    {32'h1000_0000, 2'd0, 2'd0, 1'b1, 6'd0},   // R4 code 7
    {32'h1FFF_FFFC, 2'd2, 2'd1, 1'b0, 6'd20},  // R5 code 7 user
    {32'h2000_0000, 2'd1, 2'd0, 1'b0, 6'd29},  // R4 code 13 no W
    {32'h2000_0004, 2'd2, 2'd2, 1'b1, 6'd0},   // R5 code 13
    {32'h3000_0000, 2'd1, 2'd1, 1'b1, 6'd0},   // R5 code 14
    {32'h3000_0000, 2'd2, 2'd0, 1'b0, 6'd20},  // R4 code 14 no X
    {32'h4000_0000, 2'd1, 2'd0, 1'b1, 6'd0},   // R3 disabled -> bg 15
    {32'h4800_0000, 2'd3, 2'd3, 1'b1, 6'd0},   // R3 R6 kind 3 fetch
    {32'h5000_0000, 2'd0, 2'd1, 1'b1, 6'd0},   // R5 code 11
    {32'h5000_0000, 2'd1, 2'd0, 1'b1, 6'd0},   // R4 code 11
    {32'h6000_0000, 2'd0, 2'd0, 1'b0, 6'd28},  // R4 code 0
    {32'h7000_0000, 2'd1, 2'd3, 1'b1, 6'd0},   // R5 code 15
    {32'h8FFF_FFFF, 2'd0, 2'd0, 1'b1, 6'd0},   // R1 upper edge seg6
    {32'h9000_0000, 2'd1, 2'd1, 1'b0, 6'd29},  // R5 code 10 user
    {32'hFFFF_FFFF, 2'd1, 2'd0, 1'b1, 6'd0},   // R1 last seg open-ended
    {32'h0000_0100, 2'd1, 2'd1, 1'b0, 6'd29},  // R3 no hit -> bg 7
    {32'h0000_0100, 2'd0, 2'd0, 1'b1, 6'd0}    // R3 no hit -> bg 7
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wseg(input logic [4:0] sel, input logic [31:0] addr,
                      input logic [8:0] mtype, input logic [3:0] rights, input logic en);
    @(negedge clk_i);
    seg_we_i   = 1'b1;
    seg_word_i = {11'b0, mtype, rights, 3'b0, sel};
    seg_addr_i = addr | {31'b0, en};
    @(negedge clk_i);
    seg_we_i   = 1'b0;
  endtask

  task automatic wen(input logic [31:0] v);
    @(negedge clk_i);
    en_we_i = 1'b1; en_data_i = v;
    @(negedge clk_i);
    en_we_i = 1'b0;
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic [1:0] k,
                        input logic [1:0] r, input logic eok, input logic [5:0] ecause);
    @(negedge clk_i);
    chk_valid_i = 1'b1; chk_addr_i = a; chk_kind_i = k; chk_ring_i = r;
    @(negedge clk_i);
    chk_valid_i = 1'b0;
    check({req, " R7 valid"}, 32'(res_valid_o), 32'd1);
    check({req, " ok"}, 32'(res_ok_o), 32'(eok));
    check({req, " cause"}, 32'(res_cause_o), 32'(ecause));
  endtask

  task automatic rd(input string req, input logic [4:0] s,
                    input logic [31:0] ea, input logic [31:0] et);
    rd_sel_i = s;
    #1;
    check({req, " rd_addr"}, rd_addr_o, ea);
    check({req, " rd_attr"}, rd_attr_o, et);
  endtask

  task automatic probe(input string req, input logic [31:0] a,
                       input logic [31:0] ev, input logic ef);
    probe_addr_i = a;
    #1;
    check({req, " probe"}, probe_o, ev);
    check({req, " probe_fault"}, 32'(probe_fault_o), 32'(ef));
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [42:0] e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R13 reset state
    check("R13 en", en_o, 32'h0);
    check("R13 cfg", cfg_o, 32'd8);
    check("R13 res_valid", 32'(res_valid_o), 32'd0);
    rd("R13", 5'd3, 32'h0, 32'h0);
    access("R13 R3 bg after reset", 32'h4000_0000, 2'd1, 2'd1, 1'b1, 6'd0);
    @(negedge clk_i);
    check("R7 valid drop", 32'(res_valid_o), 32'd0);

    // table setup
    wseg(5'd0, 32'h1000_0000, 9'h0, 4'd7,  1'b1);
    wseg(5'd1, 32'h2000_0000, 9'h0, 4'd13, 1'b1);
    wseg(5'd2, 32'h3000_0000, 9'h0, 4'd14, 1'b1);
    wseg(5'd3, 32'h4000_0ABC, 9'h0, 4'd5,  1'b0);
    // seg4 with junk outside the fields
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_word_i = 32'h8005_5BE4; seg_addr_i = 32'h5000_0FFF;
    @(negedge clk_i);
    seg_we_i = 1'b0;
    wseg(5'd5, 32'h6000_0000, 9'h0, 4'd0,  1'b1);
    wseg(5'd6, 32'h7000_0000, 9'h0, 4'd15, 1'b1);
    wseg(5'd7, 32'h9000_0000, 9'h0, 4'd10, 1'b1);

    // R8 readback
    rd("R8 seg3", 5'd3, 32'h4000_0000, 32'h0000_0500);
    rd("R8 seg4", 5'd4, 32'h5000_0001, 32'h0005_5B00);
    check("R8 en mask", en_o, 32'h0000_00F7);

    // R9 out-of-range writes ignored
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_word_i = 32'h0000_0F08; seg_addr_i = 32'h1234_5000;
    @(negedge clk_i);
    seg_word_i = 32'h0000_0F1F;
    @(negedge clk_i);
    seg_we_i = 1'b0;
    check("R9 en", en_o, 32'h0000_00F7);
    rd("R9 seg0", 5'd0, 32'h1000_0001, 32'h0000_0700);
    rd("R9 sel8", 5'd8, 32'h0, 32'h0);
    rd("R9 sel31", 5'd31, 32'h0, 32'h0);

    // vector table: R1 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      access($sformatf("R1/R3/R4/R5/R6 vec%0d", v), e[42:11], e[10:9], e[8:7], e[6], e[5:0]);
    end

    // R12 probe formats
    probe("R12 enabled", 32'h1000_0000, 32'h8000_0700, 1'b0);
    probe("R12 disabled", 32'h4000_0000, 32'h0000_6F03, 1'b0);
    probe("R12 nohit", 32'h0000_0100, 32'h4000_0700, 1'b0);

    // R10 mask write
    wen(32'hFFFF_FF5A);
    check("R10 masked", en_o, 32'h0000_005A);
    wen(32'h0000_00F7);

    // R11 same-cycle mask and segment write
    @(negedge clk_i);
    en_we_i = 1'b1; en_data_i = 32'h0;
    seg_we_i = 1'b1; seg_word_i = {11'b0, 9'h0, 4'd14, 3'b0, 5'd2};
    seg_addr_i = 32'h3000_0001;
    @(negedge clk_i);
    en_we_i = 1'b0; seg_we_i = 1'b0;
    check("R11 en", en_o, 32'h0000_0004);
    wen(32'h0000_00F7);

    // R14 check against pre-write table
    @(negedge clk_i);
    chk_valid_i = 1'b1; chk_addr_i = 32'h6000_0000; chk_kind_i = 2'd0; chk_ring_i = 2'd0;
    seg_we_i = 1'b1; seg_word_i = {11'b0, 9'h0, 4'd7, 3'b0, 5'd5}; seg_addr_i = 32'h6000_0001;
    @(negedge clk_i);
    chk_valid_i = 1'b0; seg_we_i = 1'b0;
    check("R14 old ok", 32'(res_ok_o), 32'd0);
    check("R14 old cause", 32'(res_cause_o), 32'd28);
    access("R14 new", 32'h6000_0000, 2'd0, 2'd0, 1'b1, 6'd0);

    // R2 multi-hit: seg5 overlaps seg1..4
    wseg(5'd5, 32'h2000_0000, 9'h0, 4'd7, 1'b1);
    access("R2 load", 32'h2000_0010, 2'd0, 2'd0, 1'b0, 6'd25);
    access("R2 store", 32'h2000_0010, 2'd1, 2'd0, 1'b0, 6'd25);
    access("R2 fetch", 32'h2000_0010, 2'd2, 2'd0, 1'b0, 6'd17);
    probe("R2", 32'h2000_0010, 32'h0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule